// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear/Toggle

This block is a 32-pin general-purpose I/O port driven from a plain memory-mapped register bus. Software stores output levels in an output-data register and chooses pin directions in a direction register. Three write-only alias registers set, clear or invert chosen output bits in a single bus write. Without them, changing one pin would need a read-modify-write, and an interrupt landing between the read and the write could undo it.

On the pad side, each input pin passes through a two-flop synchronizer. It is then masked by a per-pin digital-enable signal and captured into a read-only input register. While the port-enable input is low, capture stops and the input register keeps its last value. Each pin's output enable follows its direction bit, and each pin's output level follows its output-data bit.

The bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. A read is requested by holding `bus_rd` high for one cycle, and `bus_rdata` carries the value after the next edge. No stream interface is present, so no back-pressure exists.

Top module: `gpio_bitop_port`

## Requirements
- R1: After reset, the output-data, direction and input registers are all zero, so `pad_oe` and `pad_out` are zero and `bus_rdata` reads zero.
- R2: A write at offset 0x04 sets to 1 each output-data bit whose write-data bit is 1, and leaves every other bit unchanged.
- R3: A write at offset 0x08 clears to 0 each output-data bit whose write-data bit is 1, and leaves every other bit unchanged.
- R4: A write at offset 0x0C inverts each output-data bit whose write-data bit is 1, and leaves every other bit unchanged.
- R5: Offset 0x00 (output data) and offset 0x14 (direction) are loaded whole by a write and return their contents on a read.
- R6: Reads at offsets 0x04, 0x08 and 0x0C always return zero.
- R7: `pad_oe[i]` equals direction bit i, with 1 meaning output, and `pad_out[i]` equals output-data bit i. Both change at the clock edge that accepts the write.
- R8: A change on `pad_in` reaches the input register (offset 0x10) after exactly three clock edges: two synchronizer stages and one capture stage.
- R9: An input-register bit is captured as 0 while `pin_dig_en` for that pin is 0.
- R10: While `port_en` is low, the input register keeps its last value. Capture resumes when `port_en` returns high.
- R11: Writes to offset 0x10 and to unmapped offsets change no register. Reads at unmapped offsets return zero.
- R12: `bus_rdata` is valid one edge after a cycle with `bus_rd` high, and is zero after any cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Raw pad input levels |
| pin_dig_en | input | 32 | Per-pin digital-function enable |
| port_en | input | 1 | Input capture enable |
| pad_out | output | 32 | Per-pin output level |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
A wrong output-data or direction bit appears on `pad_out` or `pad_oe` at the first negative edge after the faulty write. Each alias write therefore has its result compared against a mask computed in the bench, just one cycle later. A fault in the input path appears only through reads of offset 0x10. The bench reads one cycle early and then exactly on time to pin down the three-edge latency. It also changes the pads while capture is frozen, so a missing hold shows up as new data on the next read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_AW = 8;

  typedef enum logic [2:0] {
    SEL_DATA, SEL_SET, SEL_CLR, SEL_TOG, SEL_IN, SEL_DIR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [BUS_AW-1:0] a);
    case (a)
      8'h00:   return SEL_DATA;
      8'h04:   return SEL_SET;
      8'h08:   return SEL_CLR;
      8'h0C:   return SEL_TOG;
      8'h10:   return SEL_IN;
      8'h14:   return SEL_DIR;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_in_capture.sv
module gpio_in_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         port_en,
  input  logic [W-1:0] dig_en,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] in_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_q <= '0;
    else if (port_en) in_q <= sync_in & dig_en;
  end

  // R10: capture frozen while port disabled
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_q));
  // R9: non-digital pins captured as zero
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> ((in_q & ~$past(dig_en)) == '0));
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] odr_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] odr_d;

  for (genvar b = 0; b < int'(W); b++) begin : g_bit
    always_comb begin
      odr_d[b] = odr_q[b];
      if (wr_en) begin
        case (sel)
          SEL_DATA: odr_d[b] = wdata[b];
          SEL_SET:  odr_d[b] = odr_q[b] | wdata[b];
          SEL_CLR:  odr_d[b] = odr_q[b] & ~wdata[b];
          SEL_TOG:  odr_d[b] = odr_q[b] ^ wdata[b];
          default:  odr_d[b] = odr_q[b];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q <= '0;
      dir_q <= '0;
    end else begin
      odr_q <= odr_d;
      if (wr_en && sel == SEL_DIR) dir_q <= wdata;
    end
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SET) |=> (odr_q == ($past(odr_q) | $past(wdata))));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CLR) |=> (odr_q == ($past(odr_q) & ~$past(wdata))));
  p_tog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_TOG) |=> (odr_q == ($past(odr_q) ^ $past(wdata))));
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_IN || sel == SEL_NONE)) |=> ($stable(odr_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_bitop_port.sv
module gpio_bitop_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_rd,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  input  logic [PINS-1:0]   pin_dig_en,
  input  logic              port_en,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  reg_sel_e      sel;
  logic [PINS-1:0] odr_q, dir_q, sync_q, in_q;

  assign sel = decode_offset(bus_addr);

  gpio_out_regs #(.W(PINS)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel),
    .wdata(bus_wdata), .odr_q(odr_q), .dir_q(dir_q)
  );

  gpio_sync_stage #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  gpio_in_capture #(.W(PINS)) u_cap (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .dig_en(pin_dig_en),
    .sync_in(sync_q), .in_q(in_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (!bus_rd) bus_rdata <= '0;
    else begin
      case (sel)
        SEL_DATA: bus_rdata <= odr_q;
        SEL_DIR:  bus_rdata <= dir_q;
        SEL_IN:   bus_rdata <= in_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = odr_q;
  assign pad_oe  = dir_q;

  // R6: alias offsets read as zero
  p_alias_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TOG)) |=> (bus_rdata == '0));
  // R12: no read request, no data
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  // R7: pads only move on a write
  p_pad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/gpio_bitop_port_bench.sv
module gpio_bitop_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pin_dig_en = '0;
  logic        port_en = 1'b0;
  logic [31:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_bitop_port u_gpio_bitop_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pin_dig_en(pin_dig_en), .port_en(port_en),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: read data is valid at the negedge after the accepting edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("monitor underflow", 32'h1, 32'h0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 pad_out reset", pad_out, 32'h0);
    check("R1 rdata reset", bus_rdata, 32'h0);
    bus_read(8'h00, 32'h0, "R1 data reg reset");
    bus_read(8'h14, 32'h0, "R1 dir reg reset");
    bus_read(8'h10, 32'h0, "R1 input reg reset");

    bus_write(8'h00, 32'hA5A5_0000);
    check("R5 R7 pad_out after data write", pad_out, 32'hA5A5_0000);
    check("R7 pad_oe still input", pad_oe, 32'h0);
    bus_write(8'h14, 32'hFFFF_00FF);
    check("R7 pad_oe follows dir", pad_oe, 32'hFFFF_00FF);
    bus_read(8'h14, 32'hFFFF_00FF, "R5 dir readback");

    bus_write(8'h04, 32'h0000_00F0);
    check("R2 set", pad_out, 32'hA5A5_00F0);
    bus_write(8'h04, 32'h0000_0000);
    check("R2 set with zero mask", pad_out, 32'hA5A5_00F0);
    bus_write(8'h08, 32'hA000_0010);
    check("R3 clear", pad_out, 32'h05A5_00E0);
    bus_write(8'h0C, 32'hFFFF_0001);
    check("R4 toggle", pad_out, 32'hFA5A_00E1);
    bus_write(8'h0C, 32'hFFFF_0001);
    check("R4 toggle back", pad_out, 32'h05A5_00E0);
    bus_read(8'h00, 32'h05A5_00E0, "R5 data readback");
    bus_read(8'h04, 32'h0, "R6 set reads zero");
    bus_read(8'h08, 32'h0, "R6 clear reads zero");
    bus_read(8'h0C, 32'h0, "R6 toggle reads zero");

    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'h1234_5678);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    check("R11 pad_out untouched", pad_out, 32'h05A5_00E0);
    check("R11 pad_oe untouched", pad_oe, 32'hFFFF_00FF);
    bus_read(8'h10, 32'h0, "R11 input reg not written");
    bus_read(8'h18, 32'h0, "R11 unmapped reads zero");
    idle(1);
    check("R12 rdata zero without read", bus_rdata, 32'h0);

    port_en = 1'b1; pin_dig_en = 32'hFFFF_FFFF;
    pad_in = 32'h1234_5678;
    idle(2);
    bus_read(8'h10, 32'h0, "R8 input one edge early");
    bus_read(8'h10, 32'h1234_5678, "R8 input on time");

    pin_dig_en = 32'h0000_FFFF;
    idle(3);
    bus_read(8'h10, 32'h0000_5678, "R9 digital gating");

    port_en = 1'b0; pin_dig_en = 32'hFFFF_FFFF; pad_in = 32'hFFFF_FFFF;
    idle(5);
    bus_read(8'h10, 32'h0000_5678, "R10 frozen capture");
    port_en = 1'b1;
    idle(3);
    bus_read(8'h10, 32'hFFFF_FFFF, "R10 capture resumes");

    idle(2);
    check("R12 rdata idle", bus_rdata, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule